// File: doc/BRIEF.md
# Fenced Region Detiling Address Translator

This block sits on the path from a linear aperture to tiled surface memory. It holds eight region descriptors, called fences. Each fence covers a window of 4 KiB pages and records the surface pitch and whether the surface uses X or Y tiling. Every incoming byte address is compared against all valid fences, and the lowest-numbered fence that contains it is chosen. The address is then rewritten from linear row-major order into the tiled layout of that surface. An address that no fence covers leaves the block unchanged.

Software programs each fence through a 32-bit register port that addresses the two halves of the fence separately. To change a fence safely, software first writes zero to the low half, then writes the high half, and last writes the low half with the valid bit set. The hardware also clears the valid bit on any write to the high half, so a fence whose high half has just changed never takes part in matching until its low half is written again. The translated address is registered and appears one cycle after the request.

Top module: `fence_xlat`

## Requirements
- R1: A read returns the stored fields of the selected half. `reg_sel_i` is {fence index, half}, where half 1 is the high word. The low word holds window start page [31:12], Y-tile flag [1] and valid [0]. The high word holds the last page of the window [31:12] and pitch [9:0], where pitch = stride/128 - 1. All other bits read as zero.
- R2: A write to a high word clears that fence's valid bit. A write to a low word sets the valid bit from data bit 0.
- R3: A fence matches when it is valid and start page <= address[31:12] <= last page. When several fences match, the lowest-numbered one is used. A fence that is not valid is never used.
- R4: An address that matches no fence leaves with `rsp_addr_o` equal to the input address and `rsp_hit_o` = 0.
- R5: X tiling uses row = off/stride and col = off%stride, where off = addr - start. The output is start + (row/8 * (stride/512) + col/512) * 4096 + (row%8) * 512 + col%512.
- R6: Y tiling uses the same row and col. The output is start + (row/32 * (stride/128) + col/128) * 4096 + ((col%128)/16) * 512 + (row%32) * 16 + col%16.
- R7: The usable part of a window is its size rounded down to whole tile rows, where a tile row is 8 * stride bytes for X tiling and 32 * stride bytes for Y tiling. An address in the trailing partial tile row of the selected fence passes through unchanged with `rsp_hit_o` = 0.
- R8: `rsp_valid_o` is high in exactly the cycle after a cycle with `req_valid_i` high, and low otherwise.
- R9: A request in the same cycle as a descriptor write is translated with the descriptor contents from before that write.
- R10: After reset, every descriptor field is zero and `rsp_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Descriptor write strobe |
| reg_sel_i | input | 4 | {fence index, half}; half 1 selects the high word |
| reg_wdata_i | input | 32 | Descriptor write data |
| reg_rdata_o | output | 32 | Read data of the selected half |
| req_valid_i | input | 1 | Translation request valid |
| req_addr_i | input | 32 | Linear byte address |
| rsp_valid_o | output | 1 | Translated address valid, one cycle after request |
| rsp_addr_o | output | 32 | Translated or passed-through address |
| rsp_hit_o | output | 1 | Address was translated through a fence |

## Verification
A descriptor write and a translation of an address that the same fence covers can fall in the same clock cycle. The bench provokes this by clearing a Y-tiled fence's low word in the very cycle that it presents an address inside that fence. It expects that response to carry the old tiled translation with the hit flag set. It then expects the next request for the same address to pass through untranslated.

// File: rtl/fence_pkg.sv
package fence_pkg;
  localparam int ADDR_W   = 32;
  localparam int PG_SHIFT = 12;
  localparam int PG_W     = ADDR_W - PG_SHIFT;
  localparam int PITCH_W  = 10;
  localparam int UNIT_LOG2 = 7;   // pitch granule 128 B
  localparam int XW_LOG2  = 9;    // X tile 512 B wide
  localparam int XH_LOG2  = 3;    // X tile 8 rows
  localparam int YW_LOG2  = 7;    // Y tile 128 B wide
  localparam int YH_LOG2  = 5;    // Y tile 32 rows
  localparam int YS_LOG2  = 4;    // Y strip 16 B wide

  localparam int LO_VLD_BIT = 0;
  localparam int LO_Y_BIT   = 1;

  typedef struct packed {
    logic [PG_W-1:0]    start_pg;
    logic [PG_W-1:0]    last_pg;
    logic [PITCH_W-1:0] pitch;
    logic               ytile;
    logic               vld;
  } fence_t;
endpackage

// File: rtl/fence_regs.sv
module fence_regs
  import fence_pkg::*;
#(
  parameter int NUM_FENCES = 8,
  localparam int IDX_W = (NUM_FENCES > 1) ? $clog2(NUM_FENCES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W:0]       sel_i,
  input  logic [ADDR_W-1:0]    wdata_i,
  output logic [ADDR_W-1:0]    rdata_o,
  output fence_t [NUM_FENCES-1:0] fen_o
);
  logic [IDX_W-1:0] idx;
  logic             hi;
  fence_t           rf;
  logic             unused_wbits;

  assign idx = sel_i[IDX_W:1];
  assign hi  = sel_i[0];
  assign unused_wbits = ^wdata_i[PG_SHIFT-1:PITCH_W];

  for (genvar i = 0; i < NUM_FENCES; i++) begin : g_fen
    fence_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (we_i && idx == IDX_W'(i)) begin
        if (hi) begin
          q.last_pg <= wdata_i[ADDR_W-1:PG_SHIFT];
          q.pitch   <= wdata_i[PITCH_W-1:0];
          q.vld     <= 1'b0;  // half-written fence never matches
        end else begin
          q.start_pg <= wdata_i[ADDR_W-1:PG_SHIFT];
          q.ytile    <= wdata_i[LO_Y_BIT];
          q.vld      <= wdata_i[LO_VLD_BIT];
        end
      end
    end
    assign fen_o[i] = q;
  end

  assign rf = fen_o[idx];

  always_comb begin
    if (hi) rdata_o = {rf.last_pg, {(PG_SHIFT-PITCH_W){1'b0}}, rf.pitch};
    else    rdata_o = {rf.start_pg, {(PG_SHIFT-2){1'b0}}, rf.ytile, rf.vld};
  end

  AST_HI_CLR_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hi) |=> !fen_o[$past(idx)].vld); // R2
  AST_LO_SET_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hi) |=> (fen_o[$past(idx)].vld == $past(wdata_i[LO_VLD_BIT]))); // R2
endmodule

// File: rtl/fence_match.sv
module fence_match
  import fence_pkg::*;
#(
  parameter int NUM_FENCES = 8
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  fence_t [NUM_FENCES-1:0] fen_i,
  output logic                    hit_o,
  output fence_t                  sel_o
);
  logic [PG_W-1:0]       pg;
  logic [NUM_FENCES-1:0] raw;

  assign pg = addr_i[ADDR_W-1:PG_SHIFT];

  for (genvar i = 0; i < NUM_FENCES; i++) begin : g_cmp
    assign raw[i] = fen_i[i].vld &&
                    (pg >= fen_i[i].start_pg) && (pg <= fen_i[i].last_pg);
  end

  // lowest index wins: scan downwards, last writer is the lowest hit
  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    for (int i = NUM_FENCES - 1; i >= 0; i--) begin
      if (raw[i]) begin
        hit_o = 1'b1;
        sel_o = fen_i[i];
      end
    end
  end
endmodule

// File: rtl/fence_swz.sv
module fence_swz
  import fence_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  fence_t            fen_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fits_o
);
  localparam int DW = 2 * ADDR_W;

  logic [ADDR_W-1:0]   base, off, stride, row, col, tpr, trow, tcol, tidx;
  logic [PITCH_W:0]    units;
  logic [PG_SHIFT-1:0] intra;
  logic [PG_W:0]       pages;
  logic [ADDR_W:0]     size;
  logic [DW-1:0]       need_b, need;
  logic                unused_vld;

  assign unused_vld = fen_i.vld;

  always_comb begin
    base   = {fen_i.start_pg, {PG_SHIFT{1'b0}}};
    off    = addr_i - base;
    units  = {1'b0, fen_i.pitch} + (PITCH_W+1)'(1);
    stride = ADDR_W'(units) << UNIT_LOG2;
    row    = off / stride;
    col    = off % stride;
    if (fen_i.ytile) begin
      tpr   = stride >> YW_LOG2;
      trow  = row >> YH_LOG2;
      tcol  = col >> YW_LOG2;
      intra = {col[YW_LOG2-1:YS_LOG2], row[YH_LOG2-1:0], col[YS_LOG2-1:0]};
    end else begin
      tpr   = stride >> XW_LOG2;
      trow  = row >> XH_LOG2;
      tcol  = col >> XW_LOG2;
      intra = {row[XH_LOG2-1:0], col[XW_LOG2-1:0]};
    end
    tidx   = trow * tpr + tcol;
    addr_o = base + {tidx[PG_W-1:0], intra};

    // whole tile rows only
    pages  = {1'b0, fen_i.last_pg} - {1'b0, fen_i.start_pg} + (PG_W+1)'(1);
    size   = {pages, {PG_SHIFT{1'b0}}};
    need_b = (DW'(trow) + DW'(1)) * DW'(stride);
    need   = fen_i.ytile ? (need_b << YH_LOG2) : (need_b << XH_LOG2);
    fits_o = need <= DW'(size);
  end
endmodule

// File: rtl/fence_xlat.sv
module fence_xlat
  import fence_pkg::*;
#(
  parameter int NUM_FENCES = 8,
  localparam int IDX_W = (NUM_FENCES > 1) ? $clog2(NUM_FENCES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W:0]    reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic              rsp_hit_o
);
  fence_t [NUM_FENCES-1:0] fen;
  fence_t                  sel_f;
  logic                    any_hit, fits, use_xl;
  logic [ADDR_W-1:0]       xl_addr;

  fence_regs #(.NUM_FENCES(NUM_FENCES)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .fen_o   (fen)
  );

  fence_match #(.NUM_FENCES(NUM_FENCES)) i_match (
    .addr_i (req_addr_i),
    .fen_i  (fen),
    .hit_o  (any_hit),
    .sel_o  (sel_f)
  );

  fence_swz i_swz (
    .addr_i (req_addr_i),
    .fen_i  (sel_f),
    .addr_o (xl_addr),
    .fits_o (fits)
  );

  assign use_xl = any_hit && fits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_hit_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_addr_o <= use_xl ? xl_addr : req_addr_i;
        rsp_hit_o  <= use_xl;
      end
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R8
  AST_NO_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R8
  AST_MISS_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !any_hit) |=> (!rsp_hit_o && rsp_addr_o == $past(req_addr_i))); // R4
  AST_TAIL_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && any_hit && !fits) |=> (!rsp_hit_o && rsp_addr_o == $past(req_addr_i))); // R7
endmodule

// File: tb/test_fence_xlat.sv
module test_fence_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req_v = 1'b0;
  logic [31:0] req_a = '0;
  logic        rsp_v;
  logic [31:0] rsp_a;
  logic        rsp_h;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  fence_xlat i_fence_xlat (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .req_valid_i(req_v), .req_addr_i(req_a),
    .rsp_valid_o(rsp_v), .rsp_addr_o(rsp_a), .rsp_hit_o(rsp_h)
  );

  // addr, expected addr, expected hit
  localparam int NV = 15;
  localparam logic [31:0] VA [NV] = '{
    32'h0000_5000, 32'h0010_0000, 32'h0010_0800, 32'h0010_0205, 32'h0010_4000,
    32'h0010_1234, 32'h0010_9ABC, 32'h0010_FFFF, 32'h0011_0020, 32'h0020_0000,
    32'h0020_0010, 32'h0020_0200, 32'h0020_03A7, 32'h0020_4100, 32'h0030_0000};
  localparam logic [31:0] VE [NV] = '{
    32'h0000_5000, 32'h0010_0000, 32'h0010_0200, 32'h0010_1005, 32'h0010_4000,
    32'h0010_1434, 32'h0010_96BC, 32'h0010_FFFF, 32'h0011_0400, 32'h0020_0000,
    32'h0020_0200, 32'h0020_0010, 32'h0020_3417, 32'h0020_4100, 32'h0030_0000};
  localparam logic VH [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                               1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam string VT [NV] = '{"R4", "R5", "R5", "R5", "R5", "R5", "R3", "R5",
                                "R6", "R6", "R6", "R6", "R6", "R7", "R3"};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [31:0] d);
    @(negedge clk);
    sel = s;
    #1;
    d = rdata;
  endtask

  task automatic xl(input logic [31:0] a, output logic [31:0] ra,
                    output logic rh, output logic rv);
    @(negedge clk);
    req_v = 1'b1; req_a = a;
    @(negedge clk);
    req_v = 1'b0;
    ra = rsp_a; rh = rsp_h; rv = rsp_v;
  endtask

  task automatic prog(input logic [2:0] f, input logic [31:0] lo, input logic [31:0] hi);
    wr({f, 1'b0}, 32'h0);
    wr({f, 1'b1}, hi);
    wr({f, 1'b0}, lo);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R8: watchdog expired, got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, ra;
    logic rh, rv;

    // R10 reset state
    #5;
    chk("R10 rsp_valid in reset", {31'b0, rsp_v}, 32'h0);
    sel = 4'h0; #1; chk("R10 fence0 low reset", rdata, 32'h0);
    sel = 4'hB; #1; chk("R10 fence5 high reset", rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rsp_valid after reset", {31'b0, rsp_v}, 32'h0);

    prog(3'd0, 32'h0010_0001, 32'h0010_F00F);  // X, stride 2048, 64 KiB
    prog(3'd1, 32'h0020_0003, 32'h0020_4003);  // Y, stride 512, 20 KiB
    prog(3'd2, 32'h0010_8003, 32'h0011_7000);  // Y, stride 128, 64 KiB
    prog(3'd3, 32'h0030_0000, 32'h0030_F00F);  // not valid

    // R1 readback
    rd(4'h3, d); chk("R1 fence1 high", d, 32'h0020_4003);
    rd(4'h2, d); chk("R1 fence1 low", d, 32'h0020_0003);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R1 fence4 low reserved zero", d, 32'hFFFF_F003);
    wr(4'h9, 32'hFFFF_FFFF);
    rd(4'h9, d); chk("R1 fence4 high reserved zero", d, 32'hFFFF_F3FF);
    rd(4'h8, d); chk("R2 fence4 valid cleared by high write", d, 32'hFFFF_F002);

    // vector table
    for (int i = 0; i < NV; i++) begin
      xl(VA[i], ra, rh, rv);
      chk({VT[i], " addr"}, ra, VE[i]);
      chk({VT[i], " hit"}, {31'b0, rh}, {31'b0, VH[i]});
      chk("R8 rsp_valid", {31'b0, rv}, 32'h1);
    end
    @(negedge clk);
    chk("R8 rsp_valid idle", {31'b0, rsp_v}, 32'h0);

    // R2: high write disables fence 0, fence 2 takes over the overlap (R3)
    wr(4'h1, 32'h0010_F00F);
    xl(32'h0010_0800, ra, rh, rv);
    chk("R2 disabled fence passthru addr", ra, 32'h0010_0800);
    chk("R2 disabled fence hit", {31'b0, rh}, 32'h0);
    xl(32'h0010_9ABC, ra, rh, rv);
    chk("R3 next fence wins addr", ra, 32'h0010_975C);
    chk("R3 next fence wins hit", {31'b0, rh}, 32'h1);
    wr(4'h0, 32'h0010_0001);
    xl(32'h0010_0800, ra, rh, rv);
    chk("R2 re-enabled fence addr", ra, 32'h0010_0200);

    // R9: write and translate in the same cycle
    @(negedge clk);
    we = 1'b1; sel = 4'h2; wdata = 32'h0;
    req_v = 1'b1; req_a = 32'h0020_0010;
    @(negedge clk);
    we = 1'b0; req_v = 1'b0;
    chk("R9 same-cycle uses old fence addr", rsp_a, 32'h0020_0200);
    chk("R9 same-cycle uses old fence hit", {31'b0, rsp_h}, 32'h1);
    xl(32'h0020_0010, ra, rh, rv);
    chk("R9 following request sees new state", ra, 32'h0020_0010);
    chk("R9 following request hit", {31'b0, rh}, 32'h0);

    summary();
    $finish;
  end
endmodule